// File: doc/BRIEF.md
# Indexed Interrupt Redirection Register File

This block holds the programmable state of an I/O interrupt controller: an identification byte and a table of redirection entries, one per interrupt input. Software never addresses these registers directly. It first writes a register number into an index register, then reads or writes the selected register through a single 32-bit data window. The index register and the window are the only two offsets decoded on the bus. Only the low 8 address bits are compared, so the block can sit at any aligned base.

Each redirection entry is 64 bits wide and is split into a low half and a high half, each selected by its own index. Writes are filtered per field. The two status bits are owned by outside delivery logic and cannot be written. Only the destination byte of the high half is stored. A low-half write is refused when it would leave an unmasked entry pointing at an illegal vector. Every stored field is driven out continuously as a parallel output, for use by the delivery logic.

The bus is a plain strobe interface with no back-pressure. A write takes effect at the clock edge where `wr_en_i` is high. A read is sampled at the edge where `rd_en_i` is high, and its data appear on `rdata_o` with `rd_valid_o` one cycle later. A read and a write may be issued in the same cycle. In that case the read returns the state from before the write.

Top module: `ioredir_regs`

## Requirements
- R1: Only the low 8 address bits are decoded. Offset 0x00 is the index register and offset 0x10 is the data window. A read of any other offset returns 0xFFFFFFFF, and a write to any other offset changes nothing. Read data appear with `rd_valid_o` in the cycle after `rd_en_i`.
- R2: The index register stores only bits 7:0 of a write, and bits 31:8 read as zero.
- R3: Index 0x00 holds the 8-bit ID in bits 31:24. Bits 23:0 read as zero, and the ID is driven on `id_o`.
- R4: Index 0x01 is read-only. It reads the value 0x11 in bits 7:0, the entry count minus one (23) in bits 23:16, and zero elsewhere. Writes to it are ignored.
- R5: Index 0x02 always reads zero, and writes to it are ignored.
- R6: Index 0x10+2n selects the low half of entry n, and index 0x11+2n selects its high half, for n = 0..23. Any other index reads 0xFFFFFFFF through the window, and writes to it are ignored.
- R7: A low-half write stores every bit except bit 12 (delivery status) and bit 14 (remote IRR), and it leaves the high half unchanged. Reserved delivery-mode encodings in bits 10:8 are stored as written.
- R8: A high-half write stores only data bits 31:24, as destination bits 63:56. High-half bits 23:0 read as zero, and the low half is left unchanged.
- R9: A low-half write is accepted only if written bit 16 (mask) is 1, or if the written vector in bits 7:0 lies in 0x10..0xFE. Otherwise the entry is left unchanged.
- R10: After reset, every entry reads 0x00010000 in its low half (mask set) and zero in its high half, and the index register and the ID are zero.
- R11: A low-half read returns the current `dlv_status_i[n]` in bit 12 and the current `remote_irr_i[n]` in bit 14.
- R12: Each entry's vector, delivery mode, destination mode (bit 11), polarity (bit 13), trigger mode (bit 15), mask and destination are driven continuously on the field outputs.
- R13: When a read and a write are issued in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| dlv_status_i | input | N_ENT | Live delivery-status bit, one per entry |
| remote_irr_i | input | N_ENT | Live remote-IRR bit, one per entry |
| id_o | output | 8 | Stored ID byte |
| vector_o | output | N_ENT*8 | Vector of entry n at bits 8n+7:8n |
| dmode_o | output | N_ENT*3 | Delivery mode of entry n at bits 3n+2:3n |
| dst_logical_o | output | N_ENT | Destination mode bit per entry |
| active_low_o | output | N_ENT | Polarity bit per entry |
| level_o | output | N_ENT | Trigger mode bit per entry |
| masked_o | output | N_ENT | Mask bit per entry |
| dest_o | output | N_ENT*8 | Destination of entry n at bits 8n+7:8n |

## Verification
Two functions can coincide in one cycle: a window read and a window write to the same register. Each also coincides with outside logic moving the status inputs. The bench provokes the first case by raising both strobes in one cycle at a low half. The scoreboard expects the value from before the write, and a follow-up read must show the new value. For the second case, the bench toggles the status inputs between reads of an entry that was just written with both status bits set in its data. Each read must track the inputs, never the written bits.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;
  localparam logic [7:0] OFF_INDEX  = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;
  localparam logic [7:0] IX_ID      = 8'h00;
  localparam logic [7:0] IX_VER     = 8'h01;
  localparam logic [7:0] IX_ARB     = 8'h02;
  localparam logic [7:0] IX_TABLE   = 8'h10;
  localparam logic [7:0] VEC_LO     = 8'h10;
  localparam logic [7:0] VEC_HI     = 8'hFE;

  // Stored part of one redirection entry (status bits live outside).
  typedef struct packed {
    logic [7:0]  dest;
    logic [14:0] lo_top;    // low-half bits 31:17
    logic        mask;      // bit 16
    logic        trig;      // bit 15
    logic        polarity;  // bit 13
    logic        dst_mode;  // bit 11
    logic [2:0]  dmode;     // bits 10:8
    logic [7:0]  vector;    // bits 7:0
  } redir_t;

  localparam redir_t REDIR_RESET = '{dest: 8'h00, lo_top: 15'h0, mask: 1'b1,
                                     trig: 1'b0, polarity: 1'b0, dst_mode: 1'b0,
                                     dmode: 3'h0, vector: 8'h00};

  function automatic logic [31:0] lo_word(input redir_t e, input logic dlv, input logic irr);
    return {e.lo_top, e.mask, e.trig, irr, e.polarity, dlv, e.dst_mode, e.dmode, e.vector};
  endfunction

  function automatic logic lo_write_ok(input logic [31:0] w);
    return w[16] || ((w[7:0] >= VEC_LO) && (w[7:0] <= VEC_HI));
  endfunction
endpackage

// File: rtl/ioredir_index_reg.sv
module ioredir_index_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wbyte_i,
  output logic [7:0] sel_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni)   sel_o <= 8'h00;
    else if (wr_i) sel_o <= wbyte_i;
  end

  // R2: the index only moves on an index-register write
  a_r2_index_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i) |-> $stable(sel_o));
endmodule

// File: rtl/ioredir_entry.sv
module ioredir_entry
  import ioredir_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  output redir_t      ent_o
);
  redir_t nxt;

  always_comb begin
    nxt = ent_o;
    if (wr_lo_i && lo_write_ok(wdata_i)) begin
      nxt.vector   = wdata_i[7:0];
      nxt.dmode    = wdata_i[10:8];
      nxt.dst_mode = wdata_i[11];
      nxt.polarity = wdata_i[13];
      nxt.trig     = wdata_i[15];
      nxt.mask     = wdata_i[16];
      nxt.lo_top   = wdata_i[31:17];
    end
    if (wr_hi_i) nxt.dest = wdata_i[31:24];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) ent_o <= REDIR_RESET;
    else         ent_o <= nxt;
  end

  // R9: a refused low-half write leaves the entry unchanged
  a_r9_refused_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wdata_i[16] && (wdata_i[7:0] < 8'h10 || wdata_i[7:0] == 8'hFF))
      |=> $stable(ent_o));
  // R7: a low-half write never touches the destination
  a_r7_lo_keeps_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wr_hi_i) |=> $stable(ent_o.dest));
  // R8: a high-half write never touches the vector or the mask
  a_r8_hi_keeps_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_lo_i) |=> ($stable(ent_o.vector) && $stable(ent_o.mask)));
endmodule

// File: rtl/ioredir_rdmux.sv
module ioredir_rdmux
  import ioredir_pkg::*;
#(
  parameter int N_ENT   = 24,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                off_index_i,
  input  logic                off_window_i,
  input  logic [7:0]          sel_i,
  input  logic [7:0]          id_i,
  input  redir_t [N_ENT-1:0]  ents_i,
  input  logic [N_ENT-1:0]    dlv_i,
  input  logic [N_ENT-1:0]    irr_i,
  output logic [31:0]         word_o
);
  localparam int IDX_W = $clog2(N_ENT);
  localparam logic [7:0] TBL_SPAN = 8'(2 * N_ENT);
  localparam logic [7:0] LAST_ENT = 8'(N_ENT - 1);

  logic [7:0]       tbl_off;
  logic             in_tbl;
  logic [IDX_W-1:0] ent_idx;
  logic [31:0]      win_word;

  assign tbl_off = sel_i - IX_TABLE;
  assign in_tbl  = (sel_i >= IX_TABLE) && (tbl_off < TBL_SPAN);
  assign ent_idx = tbl_off[IDX_W:1];

  always_comb begin
    win_word = 32'hFFFF_FFFF;
    if (sel_i == IX_ID)       win_word = {id_i, 24'h0};
    else if (sel_i == IX_VER) win_word = {8'h00, LAST_ENT, 8'h00, VERSION};
    else if (sel_i == IX_ARB) win_word = 32'h0;
    else if (in_tbl) begin
      if (tbl_off[0]) win_word = {ents_i[ent_idx].dest, 24'h0};
      else            win_word = lo_word(ents_i[ent_idx], dlv_i[ent_idx], irr_i[ent_idx]);
    end
  end

  always_comb begin
    if (off_index_i)       word_o = {24'h0, sel_i};
    else if (off_window_i) word_o = win_word;
    else                   word_o = 32'hFFFF_FFFF;
  end
endmodule

// File: rtl/ioredir_regs.sv
module ioredir_regs
  import ioredir_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_ENT  = 24,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                rd_valid_o,
  input  logic [N_ENT-1:0]    dlv_status_i,
  input  logic [N_ENT-1:0]    remote_irr_i,
  output logic [7:0]          id_o,
  output logic [N_ENT*8-1:0]  vector_o,
  output logic [N_ENT*3-1:0]  dmode_o,
  output logic [N_ENT-1:0]    dst_logical_o,
  output logic [N_ENT-1:0]    active_low_o,
  output logic [N_ENT-1:0]    level_o,
  output logic [N_ENT-1:0]    masked_o,
  output logic [N_ENT*8-1:0]  dest_o
);
  logic [7:0]         off;
  logic               off_index, off_window;
  logic [7:0]         sel;
  logic               wr_win;
  redir_t [N_ENT-1:0] ents;
  logic [31:0]        rd_word;

  assign off        = addr_i[7:0];
  assign off_index  = (off == OFF_INDEX);
  assign off_window = (off == OFF_WINDOW);
  assign wr_win     = wr_en_i && off_window;

  ioredir_index_reg u_index (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i && off_index),
    .wbyte_i (wdata_i[7:0]),
    .sel_o   (sel)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                        id_o <= 8'h00;
    else if (wr_win && sel == IX_ID)    id_o <= wdata_i[31:24];
  end

  for (genvar n = 0; n < N_ENT; n++) begin : g_ent
    localparam logic [7:0] IX_LO = 8'(16 + 2 * n);
    localparam logic [7:0] IX_HI = 8'(17 + 2 * n);

    ioredir_entry u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_lo_i (wr_win && sel == IX_LO),
      .wr_hi_i (wr_win && sel == IX_HI),
      .wdata_i (wdata_i),
      .ent_o   (ents[n])
    );

    assign vector_o[n*8 +: 8] = ents[n].vector;
    assign dmode_o[n*3 +: 3]  = ents[n].dmode;
    assign dst_logical_o[n]   = ents[n].dst_mode;
    assign active_low_o[n]    = ents[n].polarity;
    assign level_o[n]         = ents[n].trig;
    assign masked_o[n]        = ents[n].mask;
    assign dest_o[n*8 +: 8]   = ents[n].dest;
  end

  ioredir_rdmux #(.N_ENT(N_ENT), .VERSION(VERSION)) u_rdmux (
    .off_index_i  (off_index),
    .off_window_i (off_window),
    .sel_i        (sel),
    .id_i         (id_o),
    .ents_i       (ents),
    .dlv_i        (dlv_status_i),
    .irr_i        (remote_irr_i),
    .word_o       (rd_word)
  );

  // Read data are taken from pre-write state, so R13 holds by timing.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rdata_o    <= 32'h0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_word;
    end
  end

  // R1: undecoded offsets read all ones
  a_r1_unmapped_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(rd_en_i && addr_i[7:0] != 8'h00 && addr_i[7:0] != 8'h10))
      |-> rdata_o == 32'hFFFF_FFFF);
  // R4: version register contents
  a_r4_version: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(rd_en_i && addr_i[7:0] == 8'h10 && sel == 8'h01))
      |-> (rdata_o == {8'h00, 8'(N_ENT - 1), 8'h00, VERSION}));
  // R6: unmapped indices read all ones
  a_r6_unmapped_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(rd_en_i && addr_i[7:0] == 8'h10 && sel > 8'h02 && sel < 8'h10))
      |-> rdata_o == 32'hFFFF_FFFF);
  // R3: the ID only changes on a window write at index 0
  a_r3_id_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i && addr_i[7:0] == 8'h10 && sel == 8'h00) |-> $stable(id_o));
endmodule

// File: tb/ioredir_regs_tb.sv
module ioredir_regs_tb;
  localparam int N = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rd_valid;
  logic [N-1:0] dlv = '0, irr = '0;
  logic [7:0] id;
  logic [N*8-1:0] vec, dest;
  logic [N*3-1:0] dmode;
  logic [N-1:0] dlog, alow, lvl, msk;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  ioredir_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .rd_valid_o(rd_valid),
    .dlv_status_i(dlv), .remote_irr_i(irr), .id_o(id), .vector_o(vec),
    .dmode_o(dmode), .dst_logical_o(dlog), .active_low_o(alow), .level_o(lvl),
    .masked_o(msk), .dest_o(dest)
  );

  // Monitor: pop and compare each read result
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data act=%h exp=none", rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s read act=%h exp=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s output act=%h exp=%h", t, act, e);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk); addr = a; rd_en = 1'b1; exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rdwr(input logic [11:0] a, input logic [31:0] d, input logic [31:0] e, input string t);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic win(input logic [7:0] ix, input logic [31:0] e, input string t);
    wr(12'h000, {24'h0, ix});
    rd(12'h010, e, t);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd(12'h000, 32'h0, "R10");
    rd(12'h010, 32'h0, "R10");
    chk("R10", {24'h0, id}, 32'h0);
    win(8'h10, 32'h0001_0000, "R10");
    win(8'h3F, 32'h0, "R10");
    chk("R10", {8'h0, msk}, {8'h0, {N{1'b1}}});
    // R2 index register width
    wr(12'h000, 32'hFFFF_FF25);
    rd(12'h000, 32'h0000_0025, "R2");
    // R1 decode: upper address bits ignored, other offsets
    rd(12'h100, 32'h0000_0025, "R1");
    rd(12'h004, 32'hFFFF_FFFF, "R1");
    wr(12'h008, 32'h0000_0002);
    rd(12'h000, 32'h0000_0025, "R1");
    // R3 ID
    wr(12'h000, 32'h0);
    wr(12'h010, 32'hA512_3456);
    rd(12'h010, 32'hA500_0000, "R3");
    chk("R3", {24'h0, id}, 32'h0000_00A5);
    // R4 version
    win(8'h01, 32'h0017_0011, "R4");
    wr(12'h010, 32'h1234_5678);
    rd(12'h010, 32'h0017_0011, "R4");
    // R5 arbitration
    win(8'h02, 32'h0, "R5");
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, 32'h0, "R5");
    // R6 unmapped indices
    win(8'h03, 32'hFFFF_FFFF, "R6");
    wr(12'h010, 32'h0000_0020);
    win(8'h0F, 32'hFFFF_FFFF, "R6");
    win(8'h40, 32'hFFFF_FFFF, "R6");
    wr(12'h010, 32'hFFFF_FFFF);
    win(8'h00, 32'hA500_0000, "R6");
    win(8'h3E, 32'h0001_0000, "R6");
    win(8'h3F, 32'h0, "R6");
    // R7 low-half write, entry 5
    win(8'h1A, 32'h0001_0000, "R7");
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, 32'hFFFF_AFFF, "R7");
    win(8'h1B, 32'h0, "R7");
    chk("R12", {24'h0, vec[47:40]}, 32'hFF);
    chk("R12", {29'h0, dmode[17:15]}, 32'h7);
    chk("R12", {28'h0, dlog[5], alow[5], lvl[5], msk[5]}, 32'hF);
    // R8 high-half write
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, 32'hFF00_0000, "R8");
    win(8'h1A, 32'hFFFF_AFFF, "R8");
    chk("R12", {24'h0, dest[47:40]}, 32'hFF);
    // R9 vector check (index still 0x1A)
    wr(12'h010, 32'h0000_0005);
    rd(12'h010, 32'hFFFF_AFFF, "R9");
    wr(12'h010, 32'h0000_00FF);
    rd(12'h010, 32'hFFFF_AFFF, "R9");
    wr(12'h010, 32'h0000_0010);
    rd(12'h010, 32'h0000_0010, "R9");
    wr(12'h010, 32'h0000_03FE);
    rd(12'h010, 32'h0000_03FE, "R7");
    wr(12'h010, 32'h0001_0002);
    rd(12'h010, 32'h0001_0002, "R9");
    win(8'h1B, 32'hFF00_0000, "R9");
    // R11 live status bits
    @(negedge clk); dlv[5] = 1'b1; irr[5] = 1'b1;
    win(8'h1A, 32'h0001_5002, "R11");
    wr(12'h010, 32'h0000_5020);
    rd(12'h010, 32'h0000_5020, "R11");
    @(negedge clk); dlv[5] = 1'b0; irr[5] = 1'b0;
    rd(12'h010, 32'h0000_0020, "R11");
    @(negedge clk); irr[5] = 1'b1;
    rd(12'h010, 32'h0000_4020, "R11");
    @(negedge clk); irr[5] = 1'b0;
    // R13 read and write in one cycle
    rdwr(12'h010, 32'h0000_0030, 32'h0000_0020, "R13");
    rd(12'h010, 32'h0000_0030, "R13");
    // R12 last entry fields
    wr(12'h000, 32'h0000_003E);
    wr(12'h010, 32'h0001_8840);
    rd(12'h010, 32'h0001_8840, "R12");
    chk("R12", {24'h0, vec[191:184]}, 32'h40);
    chk("R12", {28'h0, dlog[23], alow[23], lvl[23], msk[23]}, 32'hB);
    chk("R12", {31'h0, msk[0]}, 32'h1);
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1 missing read results act=%0d exp=0", exp_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule